// File: doc/BRIEF.md
# Programmable Twisted-Ring Clock Divider

This block divides its clock by any whole ratio from 2 to 10 using one five-stage twisted-ring (Johnson) shift register. A 4-bit ratio select picks which stage is fed back, inverted, into the first stage. An even ratio 2n takes its feedback from stage n alone. An odd ratio 2n-1 takes a NOR of stage n and stage n-1, which drops one state from the ring. All five stage outputs are visible, and the divided clock is the output of the last active stage.

A high-active clear empties the ring at once. A preset input loads a 5-bit value into the stages without waiting for a clock, so the ring can start from any chosen phase. The bits of the active part of the ring are compared with the legal ring patterns on every cycle. A pattern that can never occur in normal counting, whether preset or present at power-up, is replaced by all zeros on the next clock, so the ring cannot lock up in a wrong cycle. All pins are plain control and status pins. Nothing flows through the block, so there is no handshake.

Top module: `jring_divider`

## Requirements
- R1: While `clear` is high, all five stages read 0. This takes effect without a clock edge and wins over `preset_en`.
- R2: When `preset_en` rises, and at every clock edge while it stays high with `clear` low, the stages take `preset_val`. Bit 0 of `preset_val` goes to stage 1. While `preset_en` is high, the clock does not shift the ring.
- R3: On a rising clock edge, with `clear` and `preset_en` low and a legal active window, stage 1 takes the feedback value and each stage k (2 to 5) takes the old value of stage k-1. The inactive stages shift as well. `stage_q[0]` is stage 1.
- R4: For an even ratio 2n (n from 1 to 5), the feedback is the inverse of stage n. From all zeros, the active stages 1..n then run through 2n distinct states: they fill with ones from stage 1 upward, then empty from stage 1 upward.
- R5: For an odd ratio 2n-1 (n from 2 to 5), the feedback is NOR(stage n, stage n-1). The ring then has 2n-1 states, and the all-ones pattern of the active stages never occurs.
- R6: A `ratio_sel` value below 2 or above 10 gives exactly the behaviour of ratio 10.
- R7: The active window is stages 1..n. It is legal when at most one adjacent pair of active stages differs, and for an odd ratio it must also not be all ones. If the window is illegal at a clock edge (with `clear` and `preset_en` low), all five stages become 0 at that edge.
- R8: `div_out` equals stage n at all times. Its rising edges are exactly `ratio` clocks apart. It is high for n of the 2n clocks of an even ratio and for n-1 of the 2n-1 clocks of an odd ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the ring advances on its rising edge |
| clear | input | 1 | High-active clear of all stages, asynchronous |
| preset_en | input | 1 | High-active preset, asynchronous; loads `preset_val` |
| preset_val | input | 5 | Preset value; bit 0 goes to stage 1 |
| ratio_sel | input | 4 | Division ratio 2..10; other values select 10 |
| stage_q | output | 5 | Stage outputs; bit 0 is stage 1 |
| div_out | output | 1 | Divided clock, the last active stage |

## Verification
The hardest condition to reach is an illegal ring pattern. Once the ring is on a legal path, normal counting never leaves it, and clear only leads to the all-zero state. The bench uses the preset as a back door. For several ratios it loads each of the 32 possible patterns, releases the preset and steps one clock. It then checks that a legal pattern shifted as expected and that an illegal one collapsed to zero. Finally it checks that the ring repeats after exactly one full ratio period.

// File: rtl/jr_pkg.sv
package jr_pkg;

  // Which feedback form the selected ratio uses
  typedef enum logic {
    PARITY_EVEN = 1'b0,
    PARITY_ODD  = 1'b1
  } parity_e;

  localparam int MIN_RATIO = 2;

endpackage

// File: rtl/jr_ratio_decode.sv
module jr_ratio_decode
  import jr_pkg::*;
#(
  parameter int STAGES = 5,
  localparam int MAX_RATIO = 2 * STAGES,
  localparam int SEL_W = $clog2(MAX_RATIO + 1),
  localparam int TAP_W = $clog2(STAGES)
) (
  input  logic [SEL_W-1:0]  ratio_sel,
  output logic [TAP_W-1:0]  tap,
  output parity_e           parity,
  output logic [STAGES-1:0] win_mask
);

  logic [SEL_W-1:0] eff;
  logic [SEL_W-1:0] half_up;

  // Out-of-range requests fall back to the longest ring
  always_comb begin
    if (ratio_sel < SEL_W'(MIN_RATIO) || ratio_sel > SEL_W'(MAX_RATIO))
      eff = SEL_W'(MAX_RATIO);
    else
      eff = ratio_sel;
  end

  // Number of active stages: ceil(ratio / 2)
  assign half_up = (eff >> 1) + {{(SEL_W-1){1'b0}}, eff[0]};
  assign parity  = eff[0] ? PARITY_ODD : PARITY_EVEN;

  always_comb begin
    tap = '0;
    for (int k = 0; k < STAGES; k++) begin
      if (half_up == SEL_W'(k + 1)) tap = TAP_W'(k);
    end
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_mask
    assign win_mask[g] = (half_up > SEL_W'(g));
  end

endmodule

// File: rtl/jr_window_check.sv
module jr_window_check
  import jr_pkg::*;
#(
  parameter int STAGES = 5,
  localparam int TAP_W = $clog2(STAGES)
) (
  input  logic [STAGES-1:0] q,
  input  logic [TAP_W-1:0]  tap,
  input  parity_e           parity,
  input  logic [STAGES-1:0] win_mask,
  output logic              win_ok,
  output logic              fb,
  output logic              tail_bit,
  output logic              pre_tail_bit
);

  logic [STAGES-1:0] win;
  logic [STAGES-1:0] win_inc;
  logic [STAGES-1:0] inv;
  logic [STAGES-1:0] inv_inc;
  logic              fill_run;
  logic              drain_run;

  // Pick the last active stage and the one below it
  always_comb begin
    tail_bit     = 1'b0;
    pre_tail_bit = 1'b0;
    for (int k = 0; k < STAGES; k++) begin
      if (tap == TAP_W'(k))     tail_bit     = q[k];
      if (tap == TAP_W'(k + 1)) pre_tail_bit = q[k];
    end
  end

  // Legal window: ones packed at stage 1 (filling) or zeros packed there (draining)
  assign win       = q & win_mask;
  assign win_inc   = win + {{(STAGES-1){1'b0}}, 1'b1};
  assign inv       = ~q & win_mask;
  assign inv_inc   = inv + {{(STAGES-1){1'b0}}, 1'b1};
  assign fill_run  = ((win & win_inc) == '0);
  assign drain_run = ((inv & inv_inc) == '0);

  always_comb begin
    win_ok = fill_run || drain_run;
    if (parity == PARITY_ODD && win == win_mask) win_ok = 1'b0;
  end

  assign fb = (parity == PARITY_ODD) ? ~(tail_bit | pre_tail_bit) : ~tail_bit;

endmodule

// File: rtl/jr_stage_reg.sv
module jr_stage_reg #(
  parameter int STAGES = 5
) (
  input  logic              clk,
  input  logic              clear,
  input  logic              preset_en,
  input  logic [STAGES-1:0] preset_val,
  input  logic              win_ok,
  input  logic              fb,
  output logic [STAGES-1:0] q
);

  logic [STAGES-1:0] q_next;

  // Illegal windows collapse to the all-zero start state
  assign q_next = win_ok ? {q[STAGES-2:0], fb} : '0;

  always_ff @(posedge clk or posedge clear or posedge preset_en) begin
    if (clear)          q <= '0;
    else if (preset_en) q <= preset_val;
    else                q <= q_next;
  end

  assert_clear_hold_R1: assert property (@(posedge clk)
    (clear && $past(clear)) |-> (q == '0));

  assert_preset_load_R2: assert property (@(posedge clk) disable iff (clear)
    ($past(preset_en) && $past(!clear) && preset_en) |-> (q == $past(preset_val)));

  assert_shift_R3: assert property (@(posedge clk) disable iff (clear || preset_en)
    win_ok |=> (q == {$past(q[STAGES-2:0]), $past(fb)}));

  assert_antilock_R7: assert property (@(posedge clk) disable iff (clear || preset_en)
    (!win_ok) |=> (q == '0));

endmodule

// File: rtl/jring_divider.sv
module jring_divider
  import jr_pkg::*;
#(
  parameter int STAGES = 5,
  localparam int MAX_RATIO = 2 * STAGES,
  localparam int SEL_W = $clog2(MAX_RATIO + 1),
  localparam int TAP_W = $clog2(STAGES)
) (
  input  logic              clk,
  input  logic              clear,
  input  logic              preset_en,
  input  logic [STAGES-1:0] preset_val,
  input  logic [SEL_W-1:0]  ratio_sel,
  output logic [STAGES-1:0] stage_q,
  output logic              div_out
);

  logic [TAP_W-1:0]  tap;
  parity_e           parity;
  logic [STAGES-1:0] win_mask;
  logic              win_ok;
  logic              fb;
  logic              tail_bit;
  logic              pre_tail_bit;

  jr_ratio_decode #(.STAGES(STAGES)) u_decode (
    .ratio_sel (ratio_sel),
    .tap       (tap),
    .parity    (parity),
    .win_mask  (win_mask)
  );

  jr_window_check #(.STAGES(STAGES)) u_check (
    .q            (stage_q),
    .tap          (tap),
    .parity       (parity),
    .win_mask     (win_mask),
    .win_ok       (win_ok),
    .fb           (fb),
    .tail_bit     (tail_bit),
    .pre_tail_bit (pre_tail_bit)
  );

  jr_stage_reg #(.STAGES(STAGES)) u_ring (
    .clk        (clk),
    .clear      (clear),
    .preset_en  (preset_en),
    .preset_val (preset_val),
    .win_ok     (win_ok),
    .fb         (fb),
    .q          (stage_q)
  );

  assign div_out = tail_bit;

  assert_even_fb_R4: assert property (@(posedge clk) disable iff (clear || preset_en)
    (win_ok && parity == PARITY_EVEN) |=> (stage_q[0] == !$past(tail_bit)));

  assert_odd_fb_R5: assert property (@(posedge clk) disable iff (clear || preset_en)
    (win_ok && parity == PARITY_ODD) |=> (stage_q[0] == !($past(tail_bit) | $past(pre_tail_bit))));

endmodule

// File: tb/jring_divider_test.sv
module jring_divider_test;

  logic       clk = 1'b0;
  logic       clear = 1'b1;
  logic       preset_en = 1'b0;
  logic [4:0] preset_val = '0;
  logic [3:0] ratio_sel = 4'd10;
  logic [4:0] stage_q;
  logic       div_out;

  int tests = 0;
  int fails = 0;

  logic [4:0] exp_q[$];
  logic [4:0] msk_q[$];
  string      tag_q[$];
  logic [4:0] mon_e;
  logic [4:0] mon_m;
  string      mon_t;

  jring_divider uut (
    .clk(clk), .clear(clear), .preset_en(preset_en), .preset_val(preset_val),
    .ratio_sel(ratio_sel), .stage_q(stage_q), .div_out(div_out)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff_ratio(input int sel);
    return (sel < 2 || sel > 10) ? 10 : sel;
  endfunction

  function automatic logic [4:0] mask_of(input int n);
    return 5'((1 << n) - 1);
  endfunction

  // State i of the ring for ratio r, from the requirement wording (R4, R5)
  function automatic logic [4:0] seq_at(input int i, input int r);
    int n = (r + 1) / 2;
    int j;
    if (i < n) return 5'((1 << i) - 1);
    j = (r % 2 == 1) ? i - n + 1 : i - n;
    return mask_of(n) & ~5'((1 << j) - 1);
  endfunction

  // R7 legality: at most one change between neighbours; odd ratios exclude all ones
  function automatic bit is_legal(input logic [4:0] v, input int r);
    int n = (r + 1) / 2;
    int tr = 0;
    for (int k = 1; k < n; k++) if (v[k] != v[k-1]) tr++;
    if (r % 2 == 1 && (v & mask_of(n)) == mask_of(n)) return 1'b0;
    return tr <= 1;
  endfunction

  // Scoreboard monitor
  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      mon_e = exp_q.pop_front();
      mon_m = msk_q.pop_front();
      mon_t = tag_q.pop_front();
      check((stage_q & mon_m) == mon_e, mon_t, int'(stage_q & mon_m), int'(mon_e));
    end
  end

  task automatic do_clear();
    @(negedge clk);
    clear = 1'b1;
    preset_en = 1'b0;
    @(negedge clk);
    clear = 1'b0;
  endtask

  task automatic run_seq(input int sel, input int cycles, input string tag);
    int r = eff_ratio(sel);
    ratio_sel = 4'(sel);
    do_clear();
    @(posedge clk);
    #1;
    for (int i = 1; i <= cycles; i++) begin
      exp_q.push_back(seq_at(i % r, r));
      msk_q.push_back(mask_of((r + 1) / 2));
      tag_q.push_back(tag);
    end
    wait (exp_q.size() == 0);
  endtask

  task automatic check_div(input int sel, input string tag);
    int r = eff_ratio(sel);
    int n = (r + 1) / 2;
    int hi = (r % 2 == 1) ? n - 1 : n;
    int highs = 0;
    int last_rise = -1;
    logic prev;
    ratio_sel = 4'(sel);
    do_clear();
    prev = div_out;
    for (int s = 0; s < 4 * r; s++) begin
      @(negedge clk);
      check(div_out == stage_q[n-1], "R8 tap", int'(div_out), int'(stage_q[n-1]));
      if (div_out) highs++;
      if (div_out && !prev) begin
        if (last_rise >= 0) check(s - last_rise == r, tag, s - last_rise, r);
        last_rise = s;
      end
      prev = div_out;
    end
    check(highs == 4 * hi, "R8 duty", highs, 4 * hi);
  endtask

  task automatic antilock_sweep(input int sel);
    int r = sel;
    int n = (r + 1) / 2;
    logic [4:0] p;
    logic [4:0] expv;
    logic [4:0] snap;
    logic fbv;
    ratio_sel = 4'(sel);
    for (int pv = 0; pv < 32; pv++) begin
      p = 5'(pv);
      @(negedge clk);
      preset_val = p;
      preset_en = 1'b1;
      #2;
      check(stage_q == p, "R2 async", int'(stage_q), int'(p));
      @(negedge clk);
      check(stage_q == p, "R2 hold", int'(stage_q), int'(p));
      preset_en = 1'b0;
      @(negedge clk);
      if (is_legal(p, r)) begin
        fbv = (r % 2 == 1) ? ~(p[n-1] | p[n-2]) : ~p[n-1];
        expv = {p[3:0], fbv};
        check(stage_q == expv, "R3 step", int'(stage_q), int'(expv));
      end else begin
        check(stage_q == 5'd0, "R7 collapse", int'(stage_q), 0);
      end
      snap = stage_q;
      repeat (r) @(negedge clk);
      check(is_legal(stage_q, r) && ((stage_q & mask_of(n)) == (snap & mask_of(n))),
            "R7 rejoin", int'(stage_q & mask_of(n)), int'(snap & mask_of(n)));
    end
  endtask

  initial begin : watchdog
    #(1_500_000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [4:0] e;
    // R1: clear from time zero
    #12;
    check(stage_q == 5'd0, "R1 init", int'(stage_q), 0);
    check(div_out == 1'b0, "R1 init div", int'(div_out), 0);
    @(negedge clk);
    clear = 1'b0;

    // R3: full five-stage shift at ratio 2, inactive stages included
    ratio_sel = 4'd2;
    do_clear();
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      for (int j = 0; j < 5; j++) e[j] = (k - j >= 1) ? ((k - j) % 2 == 1) : 1'b0;
      check(stage_q == e, "R3 shift", int'(stage_q), int'(e));
    end

    // R1: asynchronous clear mid-cycle
    ratio_sel = 4'd10;
    do_clear();
    repeat (3) @(negedge clk);
    #2 clear = 1'b1;
    #1 check(stage_q == 5'd0, "R1 async", int'(stage_q), 0);
    @(negedge clk);
    // R1: clear wins over preset, across a clock edge
    preset_val = 5'h1F;
    preset_en = 1'b1;
    #2 check(stage_q == 5'd0, "R1 priority", int'(stage_q), 0);
    @(negedge clk);
    check(stage_q == 5'd0, "R1 priority edge", int'(stage_q), 0);
    preset_en = 1'b0;
    clear = 1'b0;

    // R4 / R5: sequences for every ratio
    for (int s = 2; s <= 10; s++)
      run_seq(s, 2 * s + 3, (s % 2 == 0) ? "R4 seq" : "R5 seq");
    // R6: out-of-range selects
    run_seq(0, 23, "R6 seq");
    run_seq(1, 23, "R6 seq");
    run_seq(11, 23, "R6 seq");
    run_seq(15, 23, "R6 seq");

    // R8: period and duty for every ratio, R6 for out-of-range
    for (int s = 2; s <= 10; s++) check_div(s, "R8 period");
    check_div(0, "R6 period");
    check_div(13, "R6 period");

    // R7: every preset pattern for several ratios
    antilock_sweep(10);
    antilock_sweep(7);
    antilock_sweep(4);
    antilock_sweep(3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule